// File: doc/BRIEF.md
# Memory Operation Dispatch Ordering Unit

This block sits at the dispatch stage of an out-of-order core model, in front of a memory dependency tracker. Each cycle it may be offered one operation described by three flags: it may read memory, it may write memory, and it has side effects. The unit first decides whether the operation can be admitted. It compares the flags against the occupancy of a load queue and a store queue, and returns a three-valued status. An admitted memory operation takes one entry in each queue that its flags name. Entries are released by separate retire pulses for loads and for stores.

An admitted operation then receives a group token. Operations that share a token have no ordering between them. A new group is announced to the tracker together with up to three dependency edges. Each edge points from an older group that the new group must wait for. The edges follow fixed ordering rules. Stores stay behind older stores and older loads. Loads may overtake loads. Loads overtake stores only in relaxed-alias mode. Side-effect operations act as barriers. A completion input tells the unit that a group has fully executed, so that later operations stop linking to it.

Top module: `mem_order_dispatch`

## Requirements
- R1: `status` is 0 when the offered operation can be admitted, 1 when it may read memory and the load queue is full, and 2 when it may write memory and the store queue is full. If both apply, 1 is reported. An operation with neither memory flag always sees 0.
- R2: A queue whose size parameter is 0 never reports full, however many operations it has admitted.
- R3: Each admitted operation takes one load-queue entry if it may read and one store-queue entry if it may write; `ret_load` and `ret_store` each free one entry. Once an entry is freed, a full queue admits again.
- R4: A dispatch offered while `status` is not 0 is ignored: no group, no token, no edge, no occupancy change, and no token number is used up. It sets `err`, which stays at 1 until reset.
- R5: Token numbers for new groups start at 1 after reset and increase by one for each new group. Token 0 means "no group" and is what a non-memory dispatch receives, with `grp_new` low.
- R6: Every operation that may write memory opens a new group. It gets an edge from the current store group (slot 0), from the current load group (slot 1), and from the current load-barrier group (slot 2) when that group differs from the load group. This holds in either alias mode.
- R7: A plain load (read only, no side effects) joins the current load group, with no new group and no edge, if it was opened by a plain load and no write or barrier has been dispatched since.
- R8: A plain load that opens a new group gets an edge from the current store group only when `relaxed_alias` is 0. In either mode it gets an edge from the current load-barrier group (slot 2).
- R9: A read with side effects is a load barrier. It opens a new group with edges from the current load group (slot 1), from the current load-barrier group if different (slot 2), and from the store group unless relaxed. It becomes both the current load group and the current load-barrier group. A write that also reads with side effects is a full barrier and updates all three.
- R10: A `done_valid` pulse with `done_token` equal to a current group register clears that register, so later operations get no edge to it.
- R11: After reset, `err` is 0, all three current-group registers hold 0, and both queues are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An operation is offered for dispatch |
| disp_load | input | 1 | Operation may read memory |
| disp_store | input | 1 | Operation may write memory |
| disp_side | input | 1 | Operation has side effects (barrier) |
| relaxed_alias | input | 1 | 1: loads may overtake older stores |
| done_valid | input | 1 | A group has fully executed |
| done_token | input | TOK_W | Token of the executed group |
| ret_load | input | 1 | Free one load-queue entry |
| ret_store | input | 1 | Free one store-queue entry |
| status | output | 2 | Admission status (0 ok, 1 load full, 2 store full) |
| disp_token | output | TOK_W | Group token of the dispatched operation |
| grp_new | output | 1 | A new group is created this cycle |
| dep_valid | output | 3 | Edge valid per slot: 0 store, 1 load, 2 barrier |
| dep_src | output | 3*TOK_W | Source tokens, slot k at bits [k*TOK_W +: TOK_W] |
| err | output | 1 | Sticky: a dispatch was offered while not admissible |

## Verification
The bench fills both queues at the same time. This shows whether a design that gives the store-full code priority returns 2 instead of 1 for a read-write operation, and whether a design that lets a rejected dispatch through uses up a token or moves a counter. It checks that a plain load after a store in strict mode opens a new group with a store edge. A design that joins blindly would lose that ordering, and one that ignores the relaxed flag would add the edge anyway. It checks that barriers make the next plain load depend on them. This catches designs that suppress the barrier edge because the barrier is also the current load group. Completion pulses are followed by dispatches that must carry no edge to the finished group, and a second instance with zero sizes must never report full.

// File: rtl/mo_pkg.sv
package mo_pkg;
   typedef enum logic [1:0] {
      ADM_OK      = 2'd0,
      ADM_LQ_FULL = 2'd1,
      ADM_SQ_FULL = 2'd2
   } adm_status_e;

   localparam int DEP_SLOTS = 3;
   localparam int SLOT_ST   = 0;
   localparam int SLOT_LD   = 1;
   localparam int SLOT_BAR  = 2;
endpackage

// File: rtl/mo_slot_count.sv
module mo_slot_count #(
   parameter int unsigned SIZE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic give,
   output logic full
);
   generate
      if (SIZE == 0) begin : g_unbounded
         logic unused_pins;
         assign unused_pins = ^{clk, rst_n, take, give};
         assign full = 1'b0;
      end else begin : g_bounded
         localparam int CW = $clog2(SIZE + 1);
         logic [CW-1:0] cnt;
         logic          dec;

         assign dec  = give && (cnt != '0);
         assign full = (cnt == CW'(SIZE));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (take && !dec) begin
               cnt <= cnt + 1'b1;
            end else if (dec && !take) begin
               cnt <= cnt - 1'b1;
            end
         end

         assert_no_overflow_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            cnt <= CW'(SIZE));
         assert_no_take_full_R3 : assert property (@(posedge clk) disable iff (!rst_n)
            (full && !give) |-> !take);
      end
   endgenerate
endmodule

// File: rtl/mo_order.sv
module mo_order #(
   parameter int unsigned TOK_W = 6
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 acc,
   input  logic                                 is_ld,
   input  logic                                 is_st,
   input  logic                                 side,
   input  logic                                 relaxed,
   input  logic                                 done_v,
   input  logic [TOK_W-1:0]                     done_tok,
   output logic [TOK_W-1:0]                     tok_out,
   output logic                                 new_grp,
   output logic [mo_pkg::DEP_SLOTS-1:0]         dep_v,
   output logic [mo_pkg::DEP_SLOTS*TOK_W-1:0]   dep_src
);
   import mo_pkg::*;

   logic [TOK_W-1:0] cur_ld, cur_bar, cur_st, next_id, nid;
   logic [TOK_W-1:0] eff_ld, eff_bar, eff_st;
   logic             ld_open, eff_open, join_grp, plain_ld;

   // completion this cycle hides the finished group from the new operation
   assign eff_ld   = (done_v && done_tok == cur_ld)  ? '0 : cur_ld;
   assign eff_bar  = (done_v && done_tok == cur_bar) ? '0 : cur_bar;
   assign eff_st   = (done_v && done_tok == cur_st)  ? '0 : cur_st;
   assign eff_open = ld_open && (eff_ld != '0);

   assign plain_ld = is_ld && !is_st && !side;
   assign join_grp = acc && plain_ld && eff_open;
   assign new_grp  = acc && (is_ld || is_st) && !join_grp;
   assign tok_out  = join_grp ? eff_ld : (new_grp ? next_id : '0);
   assign dep_src  = {eff_bar, eff_ld, eff_st};
   assign nid      = (next_id + 1'b1 == '0) ? TOK_W'(1) : next_id + 1'b1;

   always_comb begin
      dep_v = '0;
      if (new_grp) begin
         if (is_st) begin
            dep_v[SLOT_ST]  = (eff_st != '0);
            dep_v[SLOT_LD]  = (eff_ld != '0);
            dep_v[SLOT_BAR] = (eff_bar != '0) && (eff_bar != eff_ld);
         end else if (side) begin
            dep_v[SLOT_ST]  = !relaxed && (eff_st != '0);
            dep_v[SLOT_LD]  = (eff_ld != '0);
            dep_v[SLOT_BAR] = (eff_bar != '0) && (eff_bar != eff_ld);
         end else begin
            dep_v[SLOT_ST]  = !relaxed && (eff_st != '0);
            dep_v[SLOT_BAR] = (eff_bar != '0);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_ld  <= '0;
         cur_bar <= '0;
         cur_st  <= '0;
         ld_open <= 1'b0;
         next_id <= TOK_W'(1);
      end else begin
         cur_ld  <= eff_ld;
         cur_bar <= eff_bar;
         cur_st  <= eff_st;
         ld_open <= eff_open;
         if (new_grp) begin
            if (is_st)         cur_st  <= next_id;
            if (is_ld)         cur_ld  <= next_id;
            if (is_ld && side) cur_bar <= next_id;
            ld_open <= plain_ld;
            next_id <= nid;
         end
      end
   end

   assert_tok_nonzero_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      new_grp |-> (tok_out != '0));
   assert_join_no_edge_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (is_ld || is_st) && !new_grp) |-> (dep_v == '0));
   assert_relaxed_load_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (new_grp && is_ld && !is_st && relaxed) |-> !dep_v[SLOT_ST]);
   assert_store_tail_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (new_grp && is_st) |=> (cur_st == $past(tok_out)));
endmodule

// File: rtl/mem_order_dispatch.sv
module mem_order_dispatch #(
   parameter int unsigned LQ_SIZE = 4,
   parameter int unsigned SQ_SIZE = 3,
   parameter int unsigned TOK_W   = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 disp_valid,
   input  logic                 disp_load,
   input  logic                 disp_store,
   input  logic                 disp_side,
   input  logic                 relaxed_alias,
   input  logic                 done_valid,
   input  logic [TOK_W-1:0]     done_token,
   input  logic                 ret_load,
   input  logic                 ret_store,
   output logic [1:0]           status,
   output logic [TOK_W-1:0]     disp_token,
   output logic                 grp_new,
   output logic [2:0]           dep_valid,
   output logic [3*TOK_W-1:0]   dep_src,
   output logic                 err
);
   import mo_pkg::*;

   generate
      if (TOK_W < 2) begin : g_bad_tok
         $error("TOK_W must be at least 2");
      end
   endgenerate

   adm_status_e st_e;
   logic        lq_full, sq_full, accept, reject;

   always_comb begin
      if (disp_load && lq_full)       st_e = ADM_LQ_FULL;
      else if (disp_store && sq_full) st_e = ADM_SQ_FULL;
      else                            st_e = ADM_OK;
   end

   assign status = st_e;
   assign accept = disp_valid && (disp_load || disp_store) && (st_e == ADM_OK);
   assign reject = disp_valid && (st_e != ADM_OK);

   always_ff @(posedge clk) begin
      if (!rst_n) err <= 1'b0;
      else if (reject) err <= 1'b1;
   end

   mo_slot_count #(.SIZE(LQ_SIZE)) i_lq (
      .clk(clk), .rst_n(rst_n), .take(accept && disp_load),
      .give(ret_load), .full(lq_full));

   mo_slot_count #(.SIZE(SQ_SIZE)) i_sq (
      .clk(clk), .rst_n(rst_n), .take(accept && disp_store),
      .give(ret_store), .full(sq_full));

   mo_order #(.TOK_W(TOK_W)) i_order (
      .clk(clk), .rst_n(rst_n), .acc(accept), .is_ld(disp_load),
      .is_st(disp_store), .side(disp_side), .relaxed(relaxed_alias),
      .done_v(done_valid), .done_tok(done_token), .tok_out(disp_token),
      .new_grp(grp_new), .dep_v(dep_valid), .dep_src(dep_src));

   assert_ignored_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      reject |-> (!grp_new && dep_valid == '0));
   assert_err_sticky_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   assert_nonmem_ok_R1 : assert property (@(posedge clk) disable iff (!rst_n)
      (!disp_load && !disp_store) |-> (status == 2'd0 && !grp_new));
endmodule

// File: tb/test_mem_order_dispatch.sv
module test_mem_order_dispatch;
   localparam int TW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic disp_valid = 0, disp_load = 0, disp_store = 0, disp_side = 0;
   logic relaxed_alias = 0, done_valid = 0, ret_load = 0, ret_store = 0;
   logic [TW-1:0] done_token = '0;
   logic [1:0] status, status_u;
   logic [TW-1:0] disp_token, disp_token_u;
   logic grp_new, grp_new_u, err, err_u;
   logic [2:0] dep_valid, dep_valid_u;
   logic [3*TW-1:0] dep_src, dep_src_u;

   int n_run = 0, n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   mem_order_dispatch #(.LQ_SIZE(4), .SQ_SIZE(3), .TOK_W(TW)) i_mem_order_dispatch (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_load(disp_load),
      .disp_store(disp_store), .disp_side(disp_side), .relaxed_alias(relaxed_alias),
      .done_valid(done_valid), .done_token(done_token), .ret_load(ret_load),
      .ret_store(ret_store), .status(status), .disp_token(disp_token),
      .grp_new(grp_new), .dep_valid(dep_valid), .dep_src(dep_src), .err(err));

   mem_order_dispatch #(.LQ_SIZE(0), .SQ_SIZE(0), .TOK_W(TW)) i_mem_order_dispatch_unb (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_load(disp_load),
      .disp_store(disp_store), .disp_side(disp_side), .relaxed_alias(relaxed_alias),
      .done_valid(done_valid), .done_token(done_token), .ret_load(ret_load),
      .ret_store(ret_store), .status(status_u), .disp_token(disp_token_u),
      .grp_new(grp_new_u), .dep_valid(dep_valid_u), .dep_src(dep_src_u), .err(err_u));

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      relaxed_alias = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // offer one operation and check the same-cycle outputs
   task automatic issue(input logic l, input logic s, input logic sd,
                        input int e_st, input int e_new, input int e_tok,
                        input int e_dv, input int e_s, input int e_l, input int e_b,
                        input string tag);
      @(negedge clk);
      disp_valid = 1; disp_load = l; disp_store = s; disp_side = sd;
      #2;
      chk({tag, " status"}, status, e_st);
      chk({tag, " grp_new"}, grp_new, e_new);
      chk({tag, " token"}, disp_token, e_tok);
      chk({tag, " dep_valid"}, dep_valid, e_dv);
      if (e_dv[0]) chk({tag, " src store"}, dep_src[0 +: TW], e_s);
      if (e_dv[1]) chk({tag, " src load"}, dep_src[TW +: TW], e_l);
      if (e_dv[2]) chk({tag, " src barrier"}, dep_src[2*TW +: TW], e_b);
      @(posedge clk); #1;
      disp_valid = 0; disp_load = 0; disp_store = 0; disp_side = 0;
   endtask

   task automatic peek(input logic l, input logic s, input int e_st, input string tag);
      @(negedge clk);
      disp_load = l; disp_store = s;
      #2;
      chk({tag, " status"}, status, e_st);
      disp_load = 0; disp_store = 0;
   endtask

   task automatic pulse(input logic rl, input logic rs, input logic dv, input int tok);
      @(negedge clk);
      ret_load = rl; ret_store = rs; done_valid = dv; done_token = TW'(tok);
      @(posedge clk); #1;
      ret_load = 0; ret_store = 0; done_valid = 0; done_token = '0;
   endtask

   task automatic t_reset_state();
      do_reset();
      #2;
      chk("R11 err after reset", err, 0);
      chk("R11 status idle", status, 0);
      issue(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R5 R1 non-memory");
      issue(1, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R11 R5 first load token 1");
   endtask

   // continues from t_reset_state: token 1 is an open load group
   task automatic t_grouping();
      issue(1, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R7 load joins group");
      issue(0, 1, 0, 0, 1, 2, 3'b010, 0, 1, 0, "R6 store after loads");
      issue(0, 1, 0, 0, 1, 3, 3'b011, 2, 1, 0, "R6 store after store");
      issue(1, 0, 0, 0, 1, 4, 3'b001, 3, 0, 0, "R8 strict load edge");
      issue(0, 1, 0, 0, 1, 5, 3'b011, 3, 4, 0, "R6 store strict chain");
      relaxed_alias = 1'b1;
      issue(1, 0, 0, 0, 1, 6, 3'b000, 0, 0, 0, "R8 relaxed load no edge");
   endtask

   // queues now hold 4 loads and 3 stores
   task automatic t_full();
      relaxed_alias = 1'b0;
      peek(1, 0, 1, "R3 load queue full");
      peek(0, 1, 2, "R3 store queue full");
      peek(1, 1, 1, "R1 load full wins");
      peek(0, 0, 0, "R1 non-memory when full");
      issue(0, 1, 0, 2, 0, 0, 3'b000, 0, 0, 0, "R4 rejected store");
      chk("R4 err set", err, 1);
      pulse(0, 1, 0, 0);
      peek(0, 1, 0, "R3 store freed");
      issue(0, 1, 0, 0, 1, 7, 3'b011, 5, 6, 0, "R4 token not consumed");
      pulse(1, 0, 1, 7);
      issue(1, 0, 0, 0, 1, 8, 3'b000, 0, 0, 0, "R10 done store group");
      chk("R4 err stays", err, 1);
   endtask

   task automatic t_barrier();
      do_reset();
      issue(1, 0, 0, 0, 1, 1, 3'b000, 0, 0, 0, "R9 first load");
      issue(1, 0, 1, 0, 1, 2, 3'b010, 0, 1, 0, "R9 load barrier");
      pulse(1, 0, 0, 0);
      issue(1, 0, 0, 0, 1, 3, 3'b100, 0, 0, 2, "R9 load after barrier");
      issue(0, 1, 0, 0, 1, 4, 3'b110, 0, 3, 2, "R6 store sees barrier");
      issue(1, 1, 1, 0, 1, 5, 3'b111, 4, 3, 2, "R9 full barrier");
      issue(1, 0, 0, 0, 1, 6, 3'b101, 5, 0, 5, "R9 load after full barrier");
      pulse(0, 0, 1, 5);
      issue(0, 1, 0, 0, 1, 7, 3'b010, 0, 6, 0, "R10 barrier done");
   endtask

   task automatic t_unbounded();
      do_reset();
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         disp_valid = 1; disp_load = i[0]; disp_store = ~i[0]; disp_side = 0;
         #2;
         chk("R2 unbounded status", status_u, 0);
         @(posedge clk); #1;
         disp_valid = 0; disp_load = 0; disp_store = 0;
      end
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         disp_valid = 1; disp_load = 1; disp_store = 1;
         #2;
         chk("R2 unbounded both", status_u, 0);
         @(posedge clk); #1;
         disp_valid = 0; disp_load = 0; disp_store = 0;
      end
      chk("R2 unbounded no err", err_u, 0);
   endtask

   initial begin
      t_reset_state();
      t_grouping();
      t_full();
      t_barrier();
      t_unbounded();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule